// File: doc/BRIEF.md
# PCI Host Configuration Cycle Translator

This block turns processor accesses into PCI bus command requests for a host bridge. Software writes a configuration address word (enable, bus, device, function and register fields) to one port. It then reads or writes a second port, the data port. The block classifies each data-port access:

- a type 0 configuration cycle for the local bus, with a one-hot device select in the upper address bits;
- a type 1 configuration cycle for any other bus;
- an interrupt-acknowledge cycle for a read that carries a special field pattern;
- a special-cycle broadcast for a write that carries the same pattern.

Two selectable address maps also define a fixed interrupt-acknowledge window each. A read in the active window makes an interrupt-acknowledge request. A write there raises a transaction error and starts no cycle.

The block hands the PCI master sequencer one registered request pulse. The pulse carries the command code, the address phase value, the byte enables, the write data and the even parity over address and command. A read request holds the processor port busy until the sequencer reports target ready. The returned word then goes back to the processor, with the bytes whose enables were clear forced to zero.

Top module: `pci_cfg_xlate`

## Requirements
- R1: Writing the configuration-address port (`CADDR_BASE`) stores enable (bit 31), bus (23:16), device (15:11), function (10:8) and register (7:2). Bits 30:24 and 1:0 always read as zero. A read of that port returns the stored word. After reset the word is zero.
- R2: When the enable bit is clear, a data-port (`CDATA_BASE`) read returns 0xFFFF_FFFF and a data-port write has no effect. Neither starts a request.
- R3: With enable set and bus 0, and the fields other than the special pattern, a data-port read makes command 0b1010 and a write makes 0b1011. The address is: bit 11+device set when device is 20 or less (no such bit for devices 21 to 31), function in 10:8, register in 7:2, and 00 in bits 1:0.
- R4: With enable set and a bus other than 0, the access is a type 1 cycle (0b1010 read, 0b1011 write) even if the other fields match the special pattern. Its address holds bus, device, function and register at their register positions, zero in 31:24, and 01 in bits 1:0.
- R5: With enable set, bus 0, device 0b1_1111, function 0b111 and register 0, a data-port read makes an interrupt-acknowledge request: command 0b0000, address 0, byte enables taken from the processor access.
- R6: The same pattern on a data-port write makes a special-cycle request: command 0b0001, address 0, with the processor write data and byte enables.
- R7: With `map_sel`=0, reads in 0xBFFF_FFF0..0xBFFF_FFFF make interrupt-acknowledge requests. With `map_sel`=1, reads in 0xFEF0_0000..0xFEFF_FFFF do. An address in the window of the map that is not selected produces nothing.
- R8: A write into the active interrupt-acknowledge window pulses `cpu_err` for one cycle and makes no request. A write into the inactive window does nothing.
- R9: `req_par` equals the XOR of all 32 bits of `req_addr` and the 4 bits of `req_cmd`.
- R10: After a read request, `cpu_ready` stays low and no access is accepted until `seq_trdy` is sampled high. In the next cycle `cpu_rvalid` pulses and `cpu_rdata` equals `seq_rdata` with each byte whose request byte enable was 0 forced to zero.
- R11: Requests, errors and local read replies appear in the cycle after the accepting clock edge, as one-cycle pulses. After reset `cpu_ready` is high and no pulse is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_sel | input | 1 | Address map select: 0 map A, 1 map B |
| cpu_valid | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_be | input | 4 | Processor byte enables |
| cpu_ready | output | 1 | Block can accept an access |
| cpu_rvalid | output | 1 | Read reply pulse |
| cpu_rdata | output | 32 | Read reply data |
| cpu_err | output | 1 | Transaction error pulse |
| req_valid | output | 1 | PCI command request pulse |
| req_cmd | output | 4 | PCI command code |
| req_addr | output | 32 | Address phase value |
| req_be | output | 4 | Data phase byte enables |
| req_wdata | output | 32 | Data phase write data |
| req_par | output | 1 | Even parity over address and command |
| seq_trdy | input | 1 | Sequencer reports target ready on the read |
| seq_rdata | input | 32 | Data returned by the target |

## Verification
The hardest cases to reach are the fields that decide between cycle kinds. One is a non-zero bus whose other fields match the special pattern, which must still give a type 1 cycle. Another is a device number just above the last one-hot select position. The third is a window address that belongs to the map that is not selected. Each of these needs a configuration-address write followed by the right data-port access, or the right `map_sel`. The vector table therefore pairs every access with its own configuration word and map choice. Directed tests then hold a read outstanding and drive an access into the busy port, so they can show that the access is dropped before target ready is given.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

  typedef enum logic [3:0] {
    CMD_IACK    = 4'b0000,
    CMD_SPECIAL = 4'b0001,
    CMD_CFG_RD  = 4'b1010,
    CMD_CFG_WR  = 4'b1011
  } pci_cmd_e;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_REQ   = 2'd1,
    ACT_ERR   = 2'd2,
    ACT_LOCAL = 2'd3
  } act_e;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] regno;
  } cfg_fields_t;

  localparam logic [4:0] SPECIAL_DEV = 5'h1F;
  localparam logic [2:0] SPECIAL_FN  = 3'h7;
  localparam logic [5:0] SPECIAL_REG = 6'h00;

endpackage

// File: rtl/pcx_rst_sync.sv
module pcx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/pcx_addr_reg.sv
module pcx_addr_reg
  import pcx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output cfg_fields_t   fields,
  output logic [DW-1:0] cfg_word
);
  cfg_fields_t fields_q, fields_d;

  always_comb begin
    fields_d = fields_q;
    if (wr_en) begin
      fields_d.en    = wr_data[31];
      fields_d.bus   = wr_data[23:16];
      fields_d.dev   = wr_data[15:11];
      fields_d.fn    = wr_data[10:8];
      fields_d.regno = wr_data[7:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fields_q <= '0;
    else if (wr_en) fields_q <= fields_d;
  end

  assign fields   = fields_q;
  assign cfg_word = {fields_q.en, 7'b0, fields_q.bus, fields_q.dev,
                     fields_q.fn, fields_q.regno, 2'b00};

  // R1: a write lands in the stored word one cycle later, reserved bits dropped
  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cfg_word == ($past(wr_data) & 32'h80FF_FFFC));

  // R1: without a write the stored word holds
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_word));
endmodule

// File: rtl/pcx_classify.sv
module pcx_classify
  import pcx_pkg::*;
#(
  parameter int          DW         = 32,
  parameter logic [31:0] CADDR_BASE = 32'hFEC0_0000,
  parameter logic [31:0] CDATA_BASE = 32'hFEE0_0000,
  parameter logic [31:0] WINA_LO    = 32'hBFFF_FFF0,
  parameter logic [31:0] WINA_HI    = 32'hBFFF_FFFF,
  parameter logic [31:0] WINB_LO    = 32'hFEF0_0000,
  parameter logic [31:0] WINB_HI    = 32'hFEFF_FFFF
) (
  input  logic          we,
  input  logic [DW-1:0] addr,
  input  logic          map_sel,
  input  cfg_fields_t   fields,
  input  logic [DW-1:0] cfg_word,
  output logic          cfg_wr,
  output act_e          act,
  output pci_cmd_e      cmd,
  output logic [DW-1:0] pci_addr,
  output logic [DW-1:0] local_rdata
);
  localparam int NMAP      = 2;
  localparam int IDSEL_LSB = 11;
  localparam int IDSEL_CNT = DW - IDSEL_LSB;

  localparam logic [31:0] WIN_LO [NMAP] = '{WINA_LO, WINB_LO};
  localparam logic [31:0] WIN_HI [NMAP] = '{WINA_HI, WINB_HI};

  logic [NMAP-1:0]      win_hit;
  logic [IDSEL_CNT-1:0] idsel_oh;
  logic                 hit_caddr, hit_cdata, win_act;
  logic                 local_bus, special;
  logic [DW-1:0]        type0_addr, type1_addr;

  for (genvar m = 0; m < NMAP; m++) begin : g_win
    assign win_hit[m] = (addr >= WIN_LO[m]) && (addr <= WIN_HI[m]);
  end

  for (genvar g = 0; g < IDSEL_CNT; g++) begin : g_idsel
    assign idsel_oh[g] = (32'(fields.dev) == g);
  end

  assign hit_caddr = (addr[DW-1:2] == CADDR_BASE[DW-1:2]);
  assign hit_cdata = (addr[DW-1:2] == CDATA_BASE[DW-1:2]);
  assign win_act   = map_sel ? win_hit[1] : win_hit[0];
  assign local_bus = (fields.bus == 8'h00);
  assign special   = (fields.dev == SPECIAL_DEV) && (fields.fn == SPECIAL_FN) &&
                     (fields.regno == SPECIAL_REG);

  assign type0_addr = {idsel_oh, fields.fn, fields.regno, 2'b00};
  assign type1_addr = {8'h00, fields.bus, fields.dev, fields.fn, fields.regno, 2'b01};
  assign cfg_wr     = hit_caddr && we;

  always_comb begin
    act         = ACT_NONE;
    cmd         = CMD_CFG_RD;
    pci_addr    = '0;
    local_rdata = '1;
    if (hit_caddr) begin
      if (!we) begin
        act         = ACT_LOCAL;
        local_rdata = cfg_word;
      end
    end else if (hit_cdata) begin
      if (!fields.en) begin
        act = we ? ACT_NONE : ACT_LOCAL;
      end else if (!local_bus) begin
        act      = ACT_REQ;
        cmd      = we ? CMD_CFG_WR : CMD_CFG_RD;
        pci_addr = type1_addr;
      end else if (special) begin
        act = ACT_REQ;
        cmd = we ? CMD_SPECIAL : CMD_IACK;
      end else begin
        act      = ACT_REQ;
        cmd      = we ? CMD_CFG_WR : CMD_CFG_RD;
        pci_addr = type0_addr;
      end
    end else if (win_act) begin
      act = we ? ACT_ERR : ACT_REQ;
      cmd = CMD_IACK;
    end
  end
endmodule

// File: rtl/pcx_req_gen.sv
module pcx_req_gen
  import pcx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            we,
  input  act_e            act,
  input  pci_cmd_e        cmd,
  input  logic [DW-1:0]   pci_addr,
  input  logic [DW/8-1:0] be,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   local_rdata,
  input  logic            seq_trdy,
  input  logic [DW-1:0]   seq_rdata,
  output logic            busy,
  output logic            req_valid,
  output logic [3:0]      req_cmd,
  output logic [DW-1:0]   req_addr,
  output logic [DW/8-1:0] req_be,
  output logic [DW-1:0]   req_wdata,
  output logic            req_par,
  output logic            err,
  output logic            rvalid,
  output logic [DW-1:0]   rdata
);
  localparam int NB = DW / 8;

  logic          busy_q, busy_d;
  logic          rv_q, rv_d, err_q, err_d, rq_q, rq_d;
  logic [3:0]    cmd_q;
  logic [DW-1:0] addr_q, wdata_q, rdata_q, rdata_d;
  logic [NB-1:0] be_q;
  logic          par_q, par_d;
  logic          load_req, trdy_hit, rdata_en;
  logic [DW-1:0] seq_masked;

  for (genvar b = 0; b < NB; b++) begin : g_mask
    assign seq_masked[8*b +: 8] = be_q[b] ? seq_rdata[8*b +: 8] : 8'h00;
  end

  assign load_req = accept && (act == ACT_REQ);
  assign trdy_hit = busy_q && seq_trdy;
  assign par_d    = ^{pci_addr, cmd};

  always_comb begin
    busy_d = busy_q;
    if (trdy_hit)            busy_d = 1'b0;
    if (load_req && !we)     busy_d = 1'b1;
    rq_d     = load_req;
    err_d    = accept && (act == ACT_ERR);
    rv_d     = (accept && (act == ACT_LOCAL)) || trdy_hit;
    rdata_en = rv_d;
    rdata_d  = trdy_hit ? seq_masked : local_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rq_q   <= 1'b0;
      err_q  <= 1'b0;
      rv_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rq_q   <= rq_d;
      err_q  <= err_d;
      rv_q   <= rv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      par_q   <= 1'b0;
    end else if (load_req) begin
      cmd_q   <= cmd;
      addr_q  <= pci_addr;
      be_q    <= be;
      wdata_q <= wdata;
      par_q   <= par_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign busy      = busy_q;
  assign req_valid = rq_q;
  assign req_cmd   = cmd_q;
  assign req_addr  = addr_q;
  assign req_be    = be_q;
  assign req_wdata = wdata_q;
  assign req_par   = par_q;
  assign err       = err_q;
  assign rvalid    = rv_q;
  assign rdata     = rdata_q;

  // R10: while busy nothing new is issued
  a_r10_no_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !rq_q);

  // R10: target ready closes the read and replies next cycle
  a_r10_trdy_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && seq_trdy) |=> (rv_q && !busy_q));

  // R10: a read request always leaves the port busy
  a_r10_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_q && !cmd_q[0] && cmd_q != 4'b0001) |-> busy_q);

  // R8: an error never comes with a request
  a_r8_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_q && rq_q));
endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate
  import pcx_pkg::*;
#(
  parameter int          DW         = 32,
  parameter logic [31:0] CADDR_BASE = 32'hFEC0_0000,
  parameter logic [31:0] CDATA_BASE = 32'hFEE0_0000,
  parameter logic [31:0] WINA_LO    = 32'hBFFF_FFF0,
  parameter logic [31:0] WINA_HI    = 32'hBFFF_FFFF,
  parameter logic [31:0] WINB_LO    = 32'hFEF0_0000,
  parameter logic [31:0] WINB_HI    = 32'hFEFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          map_sel,
  input  logic          cpu_valid,
  input  logic          cpu_we,
  input  logic [31:0]   cpu_addr,
  input  logic [31:0]   cpu_wdata,
  input  logic [3:0]    cpu_be,
  output logic          cpu_ready,
  output logic          cpu_rvalid,
  output logic [31:0]   cpu_rdata,
  output logic          cpu_err,
  output logic          req_valid,
  output logic [3:0]    req_cmd,
  output logic [31:0]   req_addr,
  output logic [3:0]    req_be,
  output logic [31:0]   req_wdata,
  output logic          req_par,
  input  logic          seq_trdy,
  input  logic [31:0]   seq_rdata
);
  logic          rst_sn, accept, busy, cfg_wr;
  cfg_fields_t   fields;
  logic [DW-1:0] cfg_word, pci_addr, local_rdata;
  act_e          act;
  pci_cmd_e      cmd;

  pcx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  assign cpu_ready = !busy;
  assign accept    = cpu_valid && !busy;

  pcx_addr_reg #(.DW(DW)) u_areg (
    .clk(clk), .rst_n(rst_sn), .wr_en(accept && cfg_wr), .wr_data(cpu_wdata),
    .fields(fields), .cfg_word(cfg_word)
  );

  pcx_classify #(
    .DW(DW), .CADDR_BASE(CADDR_BASE), .CDATA_BASE(CDATA_BASE),
    .WINA_LO(WINA_LO), .WINA_HI(WINA_HI), .WINB_LO(WINB_LO), .WINB_HI(WINB_HI)
  ) u_cls (
    .we(cpu_we), .addr(cpu_addr), .map_sel(map_sel), .fields(fields),
    .cfg_word(cfg_word), .cfg_wr(cfg_wr), .act(act), .cmd(cmd),
    .pci_addr(pci_addr), .local_rdata(local_rdata)
  );

  pcx_req_gen #(.DW(DW)) u_gen (
    .clk(clk), .rst_n(rst_sn), .accept(accept), .we(cpu_we), .act(act),
    .cmd(cmd), .pci_addr(pci_addr), .be(cpu_be), .wdata(cpu_wdata),
    .local_rdata(local_rdata), .seq_trdy(seq_trdy), .seq_rdata(seq_rdata),
    .busy(busy), .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .req_par(req_par), .err(cpu_err),
    .rvalid(cpu_rvalid), .rdata(cpu_rdata)
  );

  // R2: a disabled data-port access never starts a request
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    (accept && cpu_addr[31:2] == CDATA_BASE[31:2] && !cfg_word[31]) |=> !req_valid);

  // R5: interrupt-acknowledge and special cycles drive a zero address
  a_r5_iack_addr_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid && req_cmd[3:1] == 3'b000) |-> req_addr == '0);

  // R4: configuration cycles end in 00 or 01; type 1 keeps bits 31:24 clear
  a_r4_type1_shape: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid && req_cmd[3:1] == 3'b101 && req_addr[1:0] != 2'b00)
      |-> (req_addr[1:0] == 2'b01 && req_addr[31:24] == 8'h00));

  // R9: the address phase has even parity over address and command
  a_r9_even_parity: assert property (@(posedge clk) disable iff (!rst_sn)
    req_valid |-> (^{req_addr, req_cmd, req_par}) == 1'b0);

  // R11: a request follows an accepted access by exactly one cycle
  a_r11_req_follows: assert property (@(posedge clk) disable iff (!rst_sn)
    !accept |=> !req_valid && !cpu_err);
endmodule

// File: tb/pci_cfg_xlate_tb.sv
module pci_cfg_xlate_tb;
  localparam logic [31:0] CADDR = 32'hFEC0_0000;
  localparam logic [31:0] CDATA = 32'hFEE0_0000;
  localparam logic [31:0] WDAT  = 32'h1234_5678;
  localparam logic [31:0] SDAT  = 32'hA5C3_7E19;
  localparam logic [1:0]  K_NONE = 2'd0, K_REQ = 2'd1, K_ERR = 2'd2, K_LOC = 2'd3;

  typedef struct packed {
    logic [31:0] cfg;
    logic        map;
    logic        we;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [1:0]  kind;
    logic [3:0]  cmd;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{32'h8000_1A14, 1'b0, 1'b0, CDATA,         4'hF, K_REQ,  4'hA, 32'h0000_4214, 4'd3}, // R3
    '{32'h8000_1A14, 1'b0, 1'b1, CDATA,         4'h3, K_REQ,  4'hB, 32'h0000_4214, 4'd3}, // R3
    '{32'h8000_A800, 1'b0, 1'b0, CDATA,         4'hF, K_REQ,  4'hA, 32'h0000_0000, 4'd3}, // R3
    '{32'h8000_A004, 1'b0, 1'b0, CDATA,         4'hF, K_REQ,  4'hA, 32'h8000_0004, 4'd3}, // R3
    '{32'h8005_FF00, 1'b0, 1'b0, CDATA,         4'hF, K_REQ,  4'hA, 32'h0005_FF01, 4'd4}, // R4
    '{32'h80FF_0008, 1'b0, 1'b1, CDATA,         4'hF, K_REQ,  4'hB, 32'h00FF_0009, 4'd4}, // R4
    '{32'h8000_FF00, 1'b0, 1'b0, CDATA,         4'h1, K_REQ,  4'h0, 32'h0000_0000, 4'd5}, // R5
    '{32'h8000_FF00, 1'b0, 1'b1, CDATA,         4'hF, K_REQ,  4'h1, 32'h0000_0000, 4'd6}, // R6
    '{32'h8000_FF04, 1'b0, 1'b0, CDATA,         4'hF, K_REQ,  4'hA, 32'h0000_0704, 4'd3}, // R3
    '{32'h0000_FF00, 1'b0, 1'b0, CDATA,         4'hF, K_LOC,  4'h0, 32'hFFFF_FFFF, 4'd2}, // R2
    '{32'h0000_1A14, 1'b0, 1'b1, CDATA,         4'hF, K_NONE, 4'h0, 32'h0,         4'd2}, // R2
    '{32'h0,         1'b0, 1'b0, 32'hBFFF_FFF0, 4'h1, K_REQ,  4'h0, 32'h0,         4'd7}, // R7
    '{32'h0,         1'b0, 1'b0, 32'hBFFF_FFFC, 4'h3, K_REQ,  4'h0, 32'h0,         4'd7}, // R7
    '{32'h0,         1'b0, 1'b0, 32'hBFFF_FFEC, 4'hF, K_NONE, 4'h0, 32'h0,         4'd7}, // R7
    '{32'h0,         1'b0, 1'b1, 32'hBFFF_FFF8, 4'hF, K_ERR,  4'h0, 32'h0,         4'd8}, // R8
    '{32'h0,         1'b1, 1'b0, 32'hFEF0_0000, 4'h1, K_REQ,  4'h0, 32'h0,         4'd7}, // R7
    '{32'h0,         1'b1, 1'b0, 32'hFEFF_FFFC, 4'hF, K_REQ,  4'h0, 32'h0,         4'd7}, // R7
    '{32'h0,         1'b1, 1'b0, 32'hFF00_0000, 4'hF, K_NONE, 4'h0, 32'h0,         4'd7}, // R7
    '{32'h0,         1'b1, 1'b1, 32'hFEF8_0000, 4'hF, K_ERR,  4'h0, 32'h0,         4'd8}, // R8
    '{32'h0,         1'b1, 1'b0, 32'hBFFF_FFF0, 4'hF, K_NONE, 4'h0, 32'h0,         4'd7}, // R7
    '{32'h0,         1'b0, 1'b0, 32'hFEF0_0000, 4'hF, K_NONE, 4'h0, 32'h0,         4'd7}, // R7
    '{32'h0,         1'b0, 1'b1, 32'hFEF0_0000, 4'hF, K_NONE, 4'h0, 32'h0,         4'd8}  // R8
  };

  logic        clk, rst_n, map_sel, cpu_valid, cpu_we, seq_trdy;
  logic [31:0] cpu_addr, cpu_wdata, seq_rdata;
  logic [3:0]  cpu_be;
  logic        cpu_ready, cpu_rvalid, cpu_err, req_valid, req_par;
  logic [31:0] cpu_rdata, req_addr, req_wdata;
  logic [3:0]  req_cmd, req_be;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  pci_cfg_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .map_sel(map_sel), .cpu_valid(cpu_valid),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .cpu_err(cpu_err), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_par(req_par), .seq_trdy(seq_trdy), .seq_rdata(seq_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // drive one access for one cycle, then sample at the following negedge
  task automatic cpu_op(input logic we, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic give_trdy(input logic [31:0] d);
    seq_trdy = 1'b1; seq_rdata = d;
    @(negedge clk);
    seq_trdy = 1'b0;
  endtask

  function automatic logic [31:0] bmask(input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? d[8*b +: 8] : 8'h00;
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    string rq;
    rst_n = 1'b0; map_sel = 1'b0; cpu_valid = 1'b0; cpu_we = 1'b0;
    cpu_addr = '0; cpu_wdata = '0; cpu_be = '0; seq_trdy = 1'b0; seq_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset state
    check(cpu_ready && !req_valid && !cpu_err && !cpu_rvalid, "R11", "reset idle",
          {28'h0, cpu_ready, req_valid, cpu_err, cpu_rvalid}, 32'h8);
    // R1: address register is zero after reset
    cpu_op(1'b0, CADDR, '0, 4'hF);
    check(cpu_rvalid && cpu_rdata == 32'h0, "R1", "reset cfg word", cpu_rdata, 32'h0);
    // R1: reserved bits dropped
    cpu_op(1'b1, CADDR, 32'hFFFF_FFFF, 4'hF);
    cpu_op(1'b0, CADDR, '0, 4'hF);
    check(cpu_rvalid && cpu_rdata == 32'h80FF_FFFC, "R1", "cfg readback",
          cpu_rdata, 32'h80FF_FFFC);

    for (int i = 0; i < NV; i++) begin
      rq = $sformatf("R%0d", VECS[i].rq);
      map_sel = VECS[i].map;
      cpu_op(1'b1, CADDR, VECS[i].cfg, 4'hF);
      cpu_op(VECS[i].we, VECS[i].addr, WDAT, VECS[i].be);
      case (VECS[i].kind)
        K_NONE: check(!req_valid && !cpu_err && !cpu_rvalid && cpu_ready, rq,
                      $sformatf("v%0d quiet", i),
                      {28'h0, req_valid, cpu_err, cpu_rvalid, cpu_ready}, 32'h1);
        K_ERR:  check(cpu_err && !req_valid, rq, $sformatf("v%0d error", i),
                      {30'h0, cpu_err, req_valid}, 32'h2);
        K_LOC:  check(cpu_rvalid && !req_valid && cpu_rdata == VECS[i].exp, rq,
                      $sformatf("v%0d local data", i), cpu_rdata, VECS[i].exp);
        default: begin
          check(req_valid && req_cmd == VECS[i].cmd, rq, $sformatf("v%0d cmd", i),
                {27'h0, req_valid, req_cmd}, {27'h0, 1'b1, VECS[i].cmd});
          check(req_addr == VECS[i].exp, rq, $sformatf("v%0d addr", i),
                req_addr, VECS[i].exp);
          check(req_be == VECS[i].be, rq, $sformatf("v%0d be", i),
                {28'h0, req_be}, {28'h0, VECS[i].be});
          // R9: parity over address and command
          check(req_par == ^{VECS[i].exp, VECS[i].cmd}, "R9", $sformatf("v%0d parity", i),
                {31'h0, req_par}, {31'h0, ^{VECS[i].exp, VECS[i].cmd}});
          if (VECS[i].we) begin
            check(req_wdata == WDAT && cpu_ready, rq, $sformatf("v%0d wdata", i),
                  req_wdata, WDAT);
          end else begin
            check(!cpu_ready, "R10", $sformatf("v%0d busy", i),
                  {31'h0, cpu_ready}, 32'h0);
            give_trdy(SDAT);
            check(cpu_rvalid && cpu_ready && cpu_rdata == bmask(SDAT, VECS[i].be), "R10",
                  $sformatf("v%0d returned", i), cpu_rdata, bmask(SDAT, VECS[i].be));
          end
        end
      endcase
    end

    // R11: a request lasts one cycle
    map_sel = 1'b0;
    cpu_op(1'b1, CADDR, 32'h8000_1A14, 4'hF);
    cpu_op(1'b1, CDATA, WDAT, 4'hF);
    check(req_valid, "R11", "write pulse", {31'h0, req_valid}, 32'h1);
    @(negedge clk);
    check(!req_valid, "R11", "pulse ends", {31'h0, req_valid}, 32'h0);

    // R10: access while busy is dropped, then masked return
    cpu_op(1'b0, CDATA, '0, 4'b1010);
    check(req_valid && !cpu_ready, "R10", "read opens", {30'h0, req_valid, cpu_ready}, 32'h2);
    cpu_op(1'b1, CDATA, WDAT, 4'hF);
    check(!req_valid && !cpu_ready, "R10", "busy drop", {30'h0, req_valid, cpu_ready}, 32'h0);
    repeat (3) @(negedge clk);
    check(!cpu_rvalid && !cpu_ready, "R10", "still waiting",
          {30'h0, cpu_rvalid, cpu_ready}, 32'h0);
    give_trdy(SDAT);
    check(cpu_rvalid && cpu_rdata == 32'hA500_7E00, "R10", "masked bytes",
          cpu_rdata, 32'hA500_7E00);
    @(negedge clk);
    check(!cpu_rvalid && cpu_ready, "R11", "reply pulse ends",
          {30'h0, cpu_rvalid, cpu_ready}, 32'h1);

    // R4: bus 1 with plain fields still type 1
    cpu_op(1'b1, CADDR, 32'h8001_0810, 4'hF);
    cpu_op(1'b1, CDATA, WDAT, 4'hF);
    check(req_valid && req_cmd == 4'hB && req_addr == 32'h0001_0811, "R4", "bus 1 write",
          req_addr, 32'h0001_0811);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule